// File: doc/BRIEF.md
# Store-Pair Address and Issue Unit

This unit accepts one 32-bit store-pair instruction word, checks that it belongs to the supported family, and works out the operand size and indexing form. It reads the two transfer registers and the base register through a combinational register-file read port, or takes the stack pointer when the base index is 31. From these it forms the effective address as the base plus a sign-extended 7-bit immediate that is scaled by the operand size.

The unit then drives a memory write port with a valid/ready handshake. It can send two single-width beats, the first register at the address and the second at the address plus the operand size. It can instead send one double-width beat whose halves are ordered by the selected byte order. Pre-index and post-index forms also return an updated base value for the register file or the stack pointer.

Error cases raise one-cycle flags:
- An unsupported word raises a flag for an illegal instruction.
- A misaligned stack pointer raises a fault flag.

A transfer register that aliases the base register in a writeback form is stored as zero and is flagged. Condition flags are never touched.

Top module: `pairStoreUnit`

## Requirements
- R1: A word is legal only when bits [29:27] are 101, bit 22 is 0, and bits [25:23] are 001, 010 or 011. In addition, with bit 26 clear, bits [31:30] must be 00 or 10; with bit 26 set, they must be 00, 01 or 10. A word presented on `startValid` while idle that is not legal pulses `illegal` for one cycle on the next cycle and produces no write, no writeback and no busy.
- R2: The operand size in bytes is 4 for bits [31:30]=00. For bits [31:30]=10 it is 8 when bit 26 is clear. With bit 26 set it is 8 for bits [31:30]=01 and 16 for bits [31:30]=10. In two-beat mode `memBytes` equals this size.
- R3: The byte offset is the sign-extended bits [21:15] multiplied by the operand size, and all address sums wrap modulo 2^ADDR_W. The first register index is bits [4:0], the second register index is bits [14:10], and the base index is bits [9:5].
- R4: Mode 010 (offset) and mode 011 (pre-index) store at base plus offset. Mode 001 (post-index) stores at the unmodified base. The writeback value is always base plus offset.
- R5: In two-beat mode (`pairMode` low), beat 0 carries the first register at the address and beat 1 carries the second register at the address plus the operand size. Each is the low operand-size bytes of the register, zero-extended.
- R6: With `pairMode` high, a single beat of twice the operand size goes to the address. Its data is {second, first} with `bigEndian` low and {first, second} with `bigEndian` high, each half operand-size wide.
- R7: Base index 31 selects `spValue`. If `spValue[3:0]` is not zero, `fault` pulses for one cycle on the next cycle, and no beat and no writeback follow.
- R8: For modes 001 and 011, `wbValid` pulses for one cycle in the cycle after the final beat is accepted. It carries `wbValue`, `wbIdx` equal to the base index, and `wbToSp` set when that index is 31. Mode 010 never raises `wbValid`.
- R9: The instruction is taken on a clock edge where `startValid` is high and `busy` is low. `busy` and `memValid` are high from the next cycle until the edge that accepts the last beat. A beat's address, data and size stay unchanged while `memReady` is low. `startValid` is ignored while busy.
- R10: In modes 001 and 011 with a base index other than 31, a transfer register whose index equals the base index is stored as zero. Its flag (`hazFirst` or `hazSecond`) is high while the unit is busy. In mode 010 no such substitution happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Instruction word present |
| instWord | input | 32 | Store-pair instruction word |
| pairMode | input | 1 | Merge both stores into one double-width beat |
| bigEndian | input | 1 | Half order of the merged beat |
| busy | output | 1 | Beats outstanding |
| illegal | output | 1 | One-cycle pulse for an unsupported word |
| fault | output | 1 | One-cycle pulse for a misaligned stack pointer |
| rdIdxFirst | output | 5 | Read index, first transfer register |
| rdIdxSecond | output | 5 | Read index, second transfer register |
| rdIdxBase | output | 5 | Read index, base register |
| rdDataFirst | input | 128 | First transfer register value |
| rdDataSecond | input | 128 | Second transfer register value |
| rdDataBase | input | ADDR_W | Base register value |
| spValue | input | ADDR_W | Stack pointer value |
| memValid | output | 1 | Write beat valid |
| memReady | input | 1 | Write beat accepted |
| memAddr | output | ADDR_W | Write byte address |
| memData | output | 256 | Write data, low-aligned |
| memBytes | output | 6 | Bytes in the beat |
| wbValid | output | 1 | Base writeback pulse |
| wbToSp | output | 1 | Writeback targets the stack pointer |
| wbIdx | output | 5 | Writeback register index |
| wbValue | output | ADDR_W | New base value |
| hazFirst | output | 1 | First slot replaced by zero (base alias) |
| hazSecond | output | 1 | Second slot replaced by zero (base alias) |

## Verification
The bench builds the unit with ADDR_W set to 16. With that width, a base near the top of the address range plus a positive scaled immediate wraps to a low address, and negative immediates wrap below zero. Random bases and immediates therefore hit the modular-sum case often, not just in one directed test. The 128-bit register and 256-bit beat widths are fixed by the operand sizes, so every size, the merged beats and both half orders are covered at that one build.

// File: rtl/pairStorePkg.sv
package pairStorePkg;
  localparam int REG_W  = 128;
  localparam int BEAT_W = 2 * REG_W;

  localparam logic [2:0] MODE_POST   = 3'b001;
  localparam logic [2:0] MODE_OFFSET = 3'b010;
  localparam logic [2:0] MODE_PRE    = 3'b011;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic advance;
  } strobeT;

  // decode summary handed to control
  typedef struct packed {
    logic legal;
    logic spFault;
    logic wbForm;
  } decInfoT;
endpackage

// File: rtl/pairStoreDecode.sv
module pairStoreDecode
  import pairStorePkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] spValue,
  input  logic [ADDR_W-1:0] baseRegData,
  output logic [4:0]        idxFirst,
  output logic [4:0]        idxSecond,
  output logic [4:0]        idxBase,
  output decInfoT           info,
  output logic [2:0]        sizeLog,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [ADDR_W-1:0] nextBase,
  output logic              hazFirst,
  output logic              hazSecond
);
  logic [1:0]        opc;
  logic              vecBit;
  logic [2:0]        idxMode;
  logic [6:0]        imm7;
  logic              classOk, modeOk, sizeOk, useSp, wbForm;
  logic [ADDR_W-1:0] baseVal, offset;

  assign opc       = instWord[31:30];
  assign vecBit    = instWord[26];
  assign idxMode   = instWord[25:23];
  assign imm7      = instWord[21:15];
  assign idxSecond = instWord[14:10];
  assign idxBase   = instWord[9:5];
  assign idxFirst  = instWord[4:0];

  assign classOk = (instWord[29:27] == 3'b101) && !instWord[22];
  assign modeOk  = (idxMode == MODE_POST) || (idxMode == MODE_OFFSET) || (idxMode == MODE_PRE);
  assign sizeOk  = vecBit ? (opc != 2'b11) : !opc[0];
  assign sizeLog = 3'd2 + (vecBit ? {1'b0, opc} : {2'b00, opc[1]});
  assign wbForm  = (idxMode == MODE_POST) || (idxMode == MODE_PRE);

  assign useSp     = &idxBase;
  assign baseVal   = useSp ? spValue : baseRegData;
  assign offset    = {{(ADDR_W-7){imm7[6]}}, imm7} << sizeLog;
  assign nextBase  = baseVal + offset;
  assign storeAddr = (idxMode == MODE_POST) ? baseVal : nextBase;

  assign info.legal   = classOk && modeOk && sizeOk;
  assign info.spFault = useSp && (spValue[3:0] != 4'd0);
  assign info.wbForm  = wbForm;

  assign hazFirst  = wbForm && !useSp && (idxFirst == idxBase);
  assign hazSecond = wbForm && !useSp && (idxSecond == idxBase);
endmodule

// File: rtl/pairStoreData.sv
module pairStoreData
  import pairStorePkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [ADDR_W-1:0] nextBase,
  input  logic [4:0]        idxBase,
  input  logic [2:0]        sizeLog,
  input  logic [REG_W-1:0]  dataFirst,
  input  logic [REG_W-1:0]  dataSecond,
  input  logic              hazFirstIn,
  input  logic              hazSecondIn,
  input  logic              pairIn,
  input  logic              bigIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BEAT_W-1:0] memData,
  output logic [5:0]        memBytes,
  output logic [ADDR_W-1:0] wbValue,
  output logic              wbToSp,
  output logic [4:0]        wbIdx,
  output logic              hazFirstQ,
  output logic              hazSecondQ
);
  logic [ADDR_W-1:0] addrQ;
  logic [REG_W-1:0]  firstQ, secondQ, keepMask;
  logic [2:0]        logQ;
  logic              pairQ, bigQ, beatSel;
  logic [4:0]        sizeBytes;
  logic [8:0]        halfBits;
  logic [BEAT_W-1:0] pairedData;

  assign keepMask   = {REG_W{1'b1}} >> (8'(REG_W) - (8'd8 << sizeLog));
  assign sizeBytes  = 5'd1 << logQ;
  assign halfBits   = 9'd8 << logQ;
  assign memAddr    = beatSel ? addrQ + ADDR_W'(sizeBytes) : addrQ;
  assign pairedData = bigQ ? ((BEAT_W'(firstQ) << halfBits) | BEAT_W'(secondQ))
                           : ((BEAT_W'(secondQ) << halfBits) | BEAT_W'(firstQ));
  assign memData    = pairQ ? pairedData : BEAT_W'(beatSel ? secondQ : firstQ);
  assign memBytes   = pairQ ? {sizeBytes, 1'b0} : {1'b0, sizeBytes};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; firstQ <= '0; secondQ <= '0; logQ <= 3'd2;
      pairQ <= 1'b0; bigQ <= 1'b0; beatSel <= 1'b0;
      wbValue <= '0; wbToSp <= 1'b0; wbIdx <= '0;
      hazFirstQ <= 1'b0; hazSecondQ <= 1'b0;
    end else if (strobe.capture) begin
      addrQ      <= storeAddr;
      firstQ     <= hazFirstIn ? '0 : (dataFirst & keepMask);
      secondQ    <= hazSecondIn ? '0 : (dataSecond & keepMask);
      logQ       <= sizeLog;
      pairQ      <= pairIn;
      bigQ       <= bigIn;
      beatSel    <= 1'b0;
      wbValue    <= nextBase;
      wbToSp     <= &idxBase;
      wbIdx      <= idxBase;
      hazFirstQ  <= hazFirstIn;
      hazSecondQ <= hazSecondIn;
    end else if (strobe.advance) begin
      beatSel <= 1'b1;
    end
  end

  // second beat lands one operand size above the first
  p_second_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(beatSel) |-> memAddr == $past(memAddr) + ADDR_W'(sizeBytes));
endmodule

// File: rtl/pairStoreCtrl.sv
module pairStoreCtrl
  import pairStorePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startValid,
  input  decInfoT info,
  input  logic    pairIn,
  input  logic    memReady,
  output strobeT  strobe,
  output logic    memValid,
  output logic    busy,
  output logic    wbValid,
  output logic    fault,
  output logic    illegal
);
  seqStateT state;
  logic     onePass, wbArm, accept, fire, lastBeat;

  assign busy     = (state != ST_IDLE);
  assign memValid = busy;
  assign accept   = startValid && (state == ST_IDLE);
  assign fire     = memValid && memReady;
  assign lastBeat = fire && ((state == ST_SECOND) || onePass);

  assign strobe.capture = accept && info.legal && !info.spFault;
  assign strobe.advance = (state == ST_FIRST) && fire && !onePass;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; onePass <= 1'b0; wbArm <= 1'b0;
      wbValid <= 1'b0; fault <= 1'b0; illegal <= 1'b0;
    end else begin
      wbValid <= lastBeat && wbArm;
      fault   <= accept && info.legal && info.spFault;
      illegal <= accept && !info.legal;
      case (state)
        ST_IDLE: if (strobe.capture) begin
          state   <= ST_FIRST;
          onePass <= pairIn;
          wbArm   <= info.wbForm;
        end
        ST_FIRST:  if (fire) state <= onePass ? ST_IDLE : ST_SECOND;
        ST_SECOND: if (fire) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  p_flag_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fault, illegal, wbValid}));
  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !memValid);
  p_wb_after_beat_r8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(fire) && !busy);
endmodule

// File: rtl/pairStoreUnit.sv
module pairStoreUnit
  import pairStorePkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [31:0]       instWord,
  input  logic              pairMode,
  input  logic              bigEndian,
  output logic              busy,
  output logic              illegal,
  output logic              fault,
  output logic [4:0]        rdIdxFirst,
  output logic [4:0]        rdIdxSecond,
  output logic [4:0]        rdIdxBase,
  input  logic [127:0]      rdDataFirst,
  input  logic [127:0]      rdDataSecond,
  input  logic [ADDR_W-1:0] rdDataBase,
  input  logic [ADDR_W-1:0] spValue,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [255:0]      memData,
  output logic [5:0]        memBytes,
  output logic              wbValid,
  output logic              wbToSp,
  output logic [4:0]        wbIdx,
  output logic [ADDR_W-1:0] wbValue,
  output logic              hazFirst,
  output logic              hazSecond
);
  decInfoT           info;
  strobeT            strobe;
  logic [2:0]        sizeLog;
  logic [ADDR_W-1:0] storeAddr, nextBase;
  logic              hazFirstD, hazSecondD, hazFirstQ, hazSecondQ;

  pairStoreDecode #(.ADDR_W(ADDR_W)) uDecode (
    .instWord(instWord), .spValue(spValue), .baseRegData(rdDataBase),
    .idxFirst(rdIdxFirst), .idxSecond(rdIdxSecond), .idxBase(rdIdxBase),
    .info(info), .sizeLog(sizeLog), .storeAddr(storeAddr), .nextBase(nextBase),
    .hazFirst(hazFirstD), .hazSecond(hazSecondD));

  pairStoreCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .info(info), .pairIn(pairMode),
    .memReady(memReady), .strobe(strobe), .memValid(memValid), .busy(busy),
    .wbValid(wbValid), .fault(fault), .illegal(illegal));

  pairStoreData #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .storeAddr(storeAddr), .nextBase(nextBase),
    .idxBase(rdIdxBase), .sizeLog(sizeLog), .dataFirst(rdDataFirst),
    .dataSecond(rdDataSecond), .hazFirstIn(hazFirstD), .hazSecondIn(hazSecondD),
    .pairIn(pairMode), .bigIn(bigEndian), .memAddr(memAddr), .memData(memData),
    .memBytes(memBytes), .wbValue(wbValue), .wbToSp(wbToSp), .wbIdx(wbIdx),
    .hazFirstQ(hazFirstQ), .hazSecondQ(hazSecondQ));

  assign hazFirst  = hazFirstQ && busy;
  assign hazSecond = hazSecondQ && busy;

  // a stalled beat must not change under the consumer
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData) && $stable(memBytes));
endmodule

// File: tb/pairStoreUnit_test.sv
module pairStoreUnit_test;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, startValid, pairMode, bigEndian, memReady;
  logic [31:0] instWord;
  logic busy, illegal, fault, memValid, wbValid, wbToSp, hazFirst, hazSecond;
  logic [4:0] rdIdxFirst, rdIdxSecond, rdIdxBase, wbIdx;
  logic [127:0] rdDataFirst, rdDataSecond;
  logic [AW-1:0] rdDataBase, spValue, memAddr, wbValue;
  logic [255:0] memData;
  logic [5:0] memBytes;
  logic [127:0] regs [32];

  assign rdDataFirst  = regs[rdIdxFirst];
  assign rdDataSecond = regs[rdIdxSecond];
  assign rdDataBase   = regs[rdIdxBase][AW-1:0];

  pairStoreUnit #(.ADDR_W(AW)) uut (.*);

  int nChk = 0, nFail = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] opc, input logic v, input logic [2:0] md,
                                     input logic [6:0] imm, input logic [4:0] t2, n, t);
    return {opc, 3'b101, v, md, 1'b0, imm, t2, n, t};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  task automatic runOne(input logic [31:0] w, input logic pm, be, stall, holdStart, input logic [AW-1:0] sp);
    logic [1:0] opc; logic v; logic [2:0] md; logic [4:0] n, t, t2;
    bit legal, useSp, flt, wbf, h1, h2, rdy;
    int lg, sz, nb, k;
    logic signed [31:0] offI;
    logic [AW-1:0] base, sum, addr;
    logic [127:0] mask, d1, d2;
    logic [AW-1:0] eAddr [2];
    logic [255:0] eData [2];
    logic [5:0] eBytes;
    opc = w[31:30]; v = w[26]; md = w[25:23];
    n = w[9:5]; t = w[4:0]; t2 = w[14:10];
    legal = (w[29:27] == 3'b101) && !w[22] && (md == 3'd1 || md == 3'd2 || md == 3'd3) &&
            (v ? (opc != 2'd3) : (opc == 2'd0 || opc == 2'd2));
    lg = v ? 2 + int'(opc) : (opc == 2'd2 ? 3 : 2);
    sz = 1 << lg;
    useSp = (n == 5'd31);
    base = useSp ? sp : regs[n][AW-1:0];
    flt = useSp && (sp[3:0] != 4'd0);
    offI = $signed(w[21:15]) * sz;
    sum = base + AW'(offI);
    wbf = (md == 3'd1) || (md == 3'd3);
    addr = (md == 3'd1) ? base : sum;
    h1 = wbf && !useSp && (t == n);
    h2 = wbf && !useSp && (t2 == n);
    mask = (128'(1) << (8 * sz)) - 128'(1);
    d1 = h1 ? 128'd0 : (regs[t] & mask);
    d2 = h2 ? 128'd0 : (regs[t2] & mask);
    if (pm) begin
      nb = 1; eAddr[0] = addr; eBytes = 6'(2 * sz);
      eData[0] = be ? ((256'(d1) << (8 * sz)) | 256'(d2)) : ((256'(d2) << (8 * sz)) | 256'(d1));
    end else begin
      nb = 2; eBytes = 6'(sz);
      eAddr[0] = addr; eAddr[1] = addr + AW'(sz);
      eData[0] = 256'(d1); eData[1] = 256'(d2);
    end

    @(negedge clk);
    startValid = 1'b1; instWord = w; pairMode = pm; bigEndian = be; spValue = sp;
    @(negedge clk);
    if (!holdStart) startValid = 1'b0;
    if (!legal) begin
      chk(illegal == 1'b1, "R1 illegal flag", 256'(illegal), 256'd1);
      chk(!memValid && !busy && !fault, "R1 no write", 256'({memValid, busy, fault}), 256'd0);
      @(negedge clk);
      chk(!memValid && !wbValid, "R1 stays quiet", 256'({memValid, wbValid}), 256'd0);
      return;
    end
    if (flt) begin
      chk(fault == 1'b1, "R7 fault flag", 256'(fault), 256'd1);
      chk(!memValid && !busy, "R7 no write", 256'({memValid, busy}), 256'd0);
      @(negedge clk);
      chk(!memValid && !wbValid, "R7 no writeback", 256'({memValid, wbValid}), 256'd0);
      return;
    end
    chk(hazFirst == h1 && hazSecond == h2, "R10 alias flags", 256'({hazFirst, hazSecond}), 256'({h1, h2}));
    k = 0;
    while (k < nb) begin
      chk(memValid && busy, "R9 beat valid", 256'({memValid, busy}), 256'd3);
      chk(memAddr == eAddr[k], "R4 beat address", 256'(memAddr), 256'(eAddr[k]));
      chk(memData == eData[k], pm ? "R6 merged data" : "R5 beat data", memData, eData[k]);
      chk(memBytes == eBytes, "R2 beat size", 256'(memBytes), 256'(eBytes));
      rdy = stall ? ($urandom % 3 == 0) : ($urandom % 4 != 0);
      memReady = rdy;
      @(negedge clk);
      startValid = 1'b0;
      if (rdy) k++;
    end
    memReady = 1'b0;
    chk(!busy && !memValid, "R9 done", 256'({busy, memValid}), 256'd0);
    chk(wbValid == wbf, "R8 writeback pulse", 256'(wbValid), 256'(wbf));
    if (wbf) begin
      chk(wbValue == sum, "R8 writeback value", 256'(wbValue), 256'(sum));
      chk(wbToSp == useSp && wbIdx == n, "R8 writeback target", 256'({wbToSp, wbIdx}), 256'({useSp, n}));
    end
    @(negedge clk);
    chk(!wbValid && !memValid, "R8 single pulse", 256'({wbValid, memValid}), 256'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom, $urandom, $urandom};
    regs[5][AW-1:0] = 16'hFFF0;
    rstN = 1'b0; startValid = 1'b0; instWord = '0; pairMode = 1'b0; bigEndian = 1'b0;
    memReady = 1'b0; spValue = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memValid && !wbValid && !fault && !illegal, "R9 reset state",
        256'({busy, memValid, wbValid, fault, illegal}), 256'd0);

    runOne(mk(2'b10, 1'b0, 3'b010, 7'd2, 5'd4, 5'd1, 5'd3), 1'b0, 1'b0, 1'b0, 1'b0, 16'h1000); // R3 R5
    runOne(mk(2'b10, 1'b1, 3'b011, 7'h7C, 5'd4, 5'd2, 5'd3), 1'b1, 1'b0, 1'b0, 1'b0, 16'h1000); // R6 little
    runOne(mk(2'b10, 1'b1, 3'b011, 7'h7C, 5'd4, 5'd2, 5'd3), 1'b1, 1'b1, 1'b0, 1'b0, 16'h1000); // R6 big
    runOne(mk(2'b00, 1'b0, 3'b001, 7'h7F, 5'd6, 5'd7, 5'd8), 1'b0, 1'b0, 1'b1, 1'b0, 16'h1000); // R4 post
    runOne(mk(2'b01, 1'b1, 3'b010, 7'd3, 5'd6, 5'd7, 5'd8), 1'b0, 1'b0, 1'b1, 1'b0, 16'h1000); // R2 simd 8
    runOne(mk(2'b10, 1'b0, 3'b011, 7'd1, 5'd1, 5'd31, 5'd2), 1'b0, 1'b0, 1'b0, 1'b0, 16'h2000); // R7 sp ok
    runOne(mk(2'b10, 1'b0, 3'b011, 7'd1, 5'd1, 5'd31, 5'd2), 1'b0, 1'b0, 1'b0, 1'b0, 16'h2008); // R7 fault
    runOne(mk(2'b11, 1'b0, 3'b010, 7'd1, 5'd1, 5'd2, 5'd3), 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);     // R1
    runOne(mk(2'b01, 1'b0, 3'b010, 7'd1, 5'd1, 5'd2, 5'd3), 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);     // R1
    runOne(mk(2'b10, 1'b0, 3'b000, 7'd1, 5'd1, 5'd2, 5'd3), 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);     // R1
    runOne(mk(2'b10, 1'b0, 3'b010, 7'd1, 5'd1, 5'd2, 5'd3) | 32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0); // R1 load bit
    runOne(mk(2'b10, 1'b0, 3'b011, 7'd1, 5'd9, 5'd9, 5'd9), 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);     // R10 alias
    runOne(mk(2'b10, 1'b0, 3'b010, 7'd1, 5'd9, 5'd9, 5'd9), 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);     // R10 offset keeps data
    runOne(mk(2'b10, 1'b0, 3'b010, 7'd2, 5'd4, 5'd1, 5'd3), 1'b0, 1'b0, 1'b1, 1'b1, 16'h0);     // R9 start held
    runOne(mk(2'b10, 1'b0, 3'b010, 7'd4, 5'd1, 5'd5, 5'd2), 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);     // R3 wrap

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [AW-1:0] sp;
      logic [4:0] n;
      n = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom);
      w = mk(2'($urandom), 1'($urandom), 3'($urandom % 4), 7'($urandom), 5'($urandom), n,
             ($urandom % 8 == 0) ? n : 5'($urandom));
      if ($urandom % 10 == 0) w = $urandom;
      sp = 16'($urandom);
      if ($urandom % 4 != 0) sp[3:0] = 4'd0;
      runOne(w, 1'($urandom), 1'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 5 == 0), sp);
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule